// File: doc/BRIEF.md
# Single-Cycle 32-Bit Integer Processor Core

This block is a small 32-bit processor that completes one instruction in each clock cycle. The instruction word at the current program counter is decoded, the register file is read, the arithmetic unit computes, and the data port is driven, all in the same cycle. At the next rising edge the register result, the data-memory write and the new program counter are committed. There is no pipeline, so no hazard can arise.

The core has two word-wide ports. The instruction port gives out the program counter and takes the instruction word back combinationally. The data port gives out an address, write data and a write strobe, and takes read data back combinationally. Both memories sit outside the block.

It runs a fixed set of twelve operations:

- three-register arithmetic: add, sub and signed set-less-than;
- a register-indirect jump;
- add-immediate and set-less-than-immediate;
- word load and word store;
- branch-if-equal and branch-if-not-equal;
- absolute jump and jump-and-link.

Any other encoding is treated as a no-op.

Top module: `scpu_top`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter loads 0x00400000, so `fetch_addr` shows that address in the following cycle. While `rst` is high, `mem_we` is 0.
- R2: After any instruction that is not a taken branch or a jump, `fetch_addr` advances by 4 at the next edge.
- R3: When opcode bits [31:26] are 0 and shamt bits [10:6] are 0, the funct field [5:0] selects the operation. The values are 32 for add, 34 for sub and 42 for signed set-less-than. Each reads rs [25:21] and rt [20:16] and writes rd [15:11]. The set-less-than result is 1 or 0.
- R4: Opcode 8 (add-immediate) and opcode 10 (signed set-less-than-immediate) combine rs with the sign-extended immediate [15:0] and write the result to rt.
- R5: Opcode 35 (load) and opcode 43 (store) put rs plus the sign-extended immediate on `mem_addr`. A store raises `mem_we` and drives `mem_wdata` with rt. A load writes `mem_rdata` to rt. No other instruction raises `mem_we`.
- R6: Opcode 4 branches when rs equals rt, and opcode 5 branches when they differ. A taken branch goes to pc+4 plus the sign-extended immediate shifted left by 2. A branch that is not taken goes to pc+4.
- R7: Opcode 2 (jump) and opcode 3 (jump-and-link) go to the upper 4 bits of pc+4 joined with index [25:0] shifted left by 2. Jump-and-link also writes pc+4 into register 31.
- R8: Opcode 0 with funct 8 loads the program counter from rs.
- R9: Register 0 always reads as zero, and a write to it has no effect.
- R10: Any other opcode or funct, and any opcode-0 word with a nonzero shamt, writes no register, does not raise `mem_we` and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fetch_addr | output | 32 | Address of the instruction executing now |
| fetch_word | input | 32 | Instruction word at `fetch_addr` (combinational) |
| mem_addr | output | 32 | Data address (ALU result) |
| mem_wdata | output | 32 | Store data (rt value) |
| mem_we | output | 1 | Store strobe, committed by memory at the next edge |
| mem_rdata | input | 32 | Load data at `mem_addr` (combinational) |

## Verification
`mem_addr`, `mem_wdata` and `mem_we` follow the current instruction within the same cycle. The program counter and register writes take effect at the next rising edge. The bench therefore applies each instruction word just after a falling edge and samples the data port 1 ns later. It checks `fetch_addr` in that same window, where it already reflects the previous instruction's next-PC result. Register contents, which have no port of their own, are observed by later stores. Each store is placed after the instruction that wrote the register, so the value crossed one clock edge before it is checked.

// File: rtl/scpu_pkg.sv
package scpu_pkg;

    localparam int XLEN     = 32;
    localparam int REG_CNT  = 32;
    localparam int REG_AW   = $clog2(REG_CNT);
    localparam int IMM_W    = 16;
    localparam int JIDX_W   = 26;
    localparam logic [REG_AW-1:0] LINK_REG = REG_AW'(REG_CNT - 1);

    // Primary opcodes (bits 31:26)
    localparam logic [5:0] OPC_REG   = 6'd0;
    localparam logic [5:0] OPC_JMP   = 6'd2;
    localparam logic [5:0] OPC_JLINK = 6'd3;
    localparam logic [5:0] OPC_BREQ  = 6'd4;
    localparam logic [5:0] OPC_BRNE  = 6'd5;
    localparam logic [5:0] OPC_ADDI  = 6'd8;
    localparam logic [5:0] OPC_SLTI  = 6'd10;
    localparam logic [5:0] OPC_LOAD  = 6'd35;
    localparam logic [5:0] OPC_STORE = 6'd43;

    // Function codes (bits 5:0) under OPC_REG
    localparam logic [5:0] FN_JREG = 6'd8;
    localparam logic [5:0] FN_ADD  = 6'd32;
    localparam logic [5:0] FN_SUB  = 6'd34;
    localparam logic [5:0] FN_SLT  = 6'd42;

    typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_SLT} alu_op_e;
    typedef enum logic [1:0] {NPC_SEQ, NPC_BRANCH, NPC_JUMP, NPC_REG} npc_sel_e;
    typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_LINK} wb_sel_e;
    typedef enum logic [1:0] {DST_RD, DST_RT, DST_LINK} dst_sel_e;

    // Register-format view of an instruction word
    typedef struct packed {
        logic [5:0]        opc;
        logic [REG_AW-1:0] rs;
        logic [REG_AW-1:0] rt;
        logic [REG_AW-1:0] rd;
        logic [4:0]        shamt;
        logic [5:0]        fn;
    } insn_t;

    typedef struct packed {
        logic     reg_we;
        dst_sel_e dst;
        wb_sel_e  wb;
        alu_op_e  alu_op;
        logic     use_imm;
        logic     mem_we;
        npc_sel_e npc;
        logic     br_ne;
        logic     illegal;
    } ctrl_t;

    localparam ctrl_t CTRL_NOP = '{
        reg_we: 1'b0, dst: DST_RD, wb: WB_ALU, alu_op: ALU_ADD, use_imm: 1'b0,
        mem_we: 1'b0, npc: NPC_SEQ, br_ne: 1'b0, illegal: 1'b0
    };

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
    endfunction

endpackage

// File: rtl/scpu_decode.sv
module scpu_decode
    import scpu_pkg::*;
(
    input  logic [5:0] opc,
    input  logic [4:0] shamt,
    input  logic [5:0] fn,
    output ctrl_t      ctl
);
    always_comb begin
        ctl = CTRL_NOP;
        unique case (opc)
            OPC_REG: begin
                if (shamt != 5'd0) begin
                    ctl.illegal = 1'b1;
                end else begin
                    unique case (fn)
                        FN_ADD: begin ctl.reg_we = 1'b1; ctl.alu_op = ALU_ADD; end
                        FN_SUB: begin ctl.reg_we = 1'b1; ctl.alu_op = ALU_SUB; end
                        FN_SLT: begin ctl.reg_we = 1'b1; ctl.alu_op = ALU_SLT; end
                        FN_JREG: ctl.npc = NPC_REG;
                        default: ctl.illegal = 1'b1;
                    endcase
                end
            end
            OPC_ADDI: begin
                ctl.reg_we = 1'b1; ctl.dst = DST_RT; ctl.use_imm = 1'b1;
            end
            OPC_SLTI: begin
                ctl.reg_we = 1'b1; ctl.dst = DST_RT; ctl.use_imm = 1'b1;
                ctl.alu_op = ALU_SLT;
            end
            OPC_LOAD: begin
                ctl.reg_we = 1'b1; ctl.dst = DST_RT; ctl.use_imm = 1'b1;
                ctl.wb = WB_MEM;
            end
            OPC_STORE: begin
                ctl.mem_we = 1'b1; ctl.use_imm = 1'b1;
            end
            OPC_BREQ: ctl.npc = NPC_BRANCH;
            OPC_BRNE: begin ctl.npc = NPC_BRANCH; ctl.br_ne = 1'b1; end
            OPC_JMP:  ctl.npc = NPC_JUMP;
            OPC_JLINK: begin
                ctl.npc = NPC_JUMP; ctl.reg_we = 1'b1;
                ctl.dst = DST_LINK; ctl.wb = WB_LINK;
            end
            default: ctl.illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/scpu_regfile.sv
module scpu_regfile #(
    parameter int DW    = 32,
    parameter int NREGS = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_a,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] regs [NREGS];

    // Entry 0 is never written; reads of index 0 are forced to zero (R9)
    always_ff @(posedge clk) begin
        if (we && waddr != '0) regs[waddr] <= wdata;
    end

    assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
    assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
endmodule

// File: rtl/scpu_alu.sv
module scpu_alu
    import scpu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         eq
);
    always_comb begin
        unique case (op)
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    assign eq = (a == b);
endmodule

// File: rtl/scpu_nextpc.sv
module scpu_nextpc
    import scpu_pkg::*;
#(
    parameter int W      = 32,
    parameter int IDX_W  = 26,
    localparam int TOP_W = W - IDX_W - 2
) (
    input  logic [W-1:0]     pc,
    input  logic [W-1:0]     imm_ext,
    input  logic [IDX_W-1:0] jidx,
    input  logic [W-1:0]     reg_target,
    input  npc_sel_e         sel,
    input  logic             br_ne,
    input  logic             eq,
    output logic [W-1:0]     pc_plus4,
    output logic [W-1:0]     next_pc
);
    logic [W-1:0] br_target;
    logic         taken;

    assign pc_plus4  = pc + W'(4);
    assign br_target = pc_plus4 + {imm_ext[W-3:0], 2'b00};
    assign taken     = eq ^ br_ne;

    always_comb begin
        unique case (sel)
            NPC_BRANCH: next_pc = taken ? br_target : pc_plus4;
            NPC_JUMP:   next_pc = {pc_plus4[W-1 -: TOP_W], jidx, 2'b00};
            NPC_REG:    next_pc = reg_target;
            default:    next_pc = pc_plus4;
        endcase
    end
endmodule

// File: rtl/scpu_top.sv
module scpu_top
    import scpu_pkg::*;
#(
    parameter logic [31:0] RESET_ADDR = 32'h0040_0000
) (
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] fetch_addr,
    input  logic [31:0] fetch_word,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    output logic        mem_we,
    input  logic [31:0] mem_rdata
);
    insn_t             ins;
    ctrl_t             ctl;
    logic [XLEN-1:0]   pc_q, pc_next, pc_plus4;
    logic [XLEN-1:0]   rs_val, rt_val, imm_ext, alu_b, alu_y;
    logic              alu_eq;
    logic              rf_we;
    logic [REG_AW-1:0] rf_waddr;
    logic [XLEN-1:0]   rf_wdata;

    assign ins     = insn_t'(fetch_word);
    assign imm_ext = sext_imm(fetch_word[IMM_W-1:0]);

    scpu_decode u_dec (
        .opc   (ins.opc),
        .shamt (ins.shamt),
        .fn    (ins.fn),
        .ctl   (ctl)
    );

    scpu_regfile #(.DW(XLEN), .NREGS(REG_CNT)) u_rf (
        .clk     (clk),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (ins.rs),
        .raddr_b (ins.rt),
        .rdata_a (rs_val),
        .rdata_b (rt_val)
    );

    assign alu_b = ctl.use_imm ? imm_ext : rt_val;

    scpu_alu #(.W(XLEN)) u_alu (
        .a  (rs_val),
        .b  (alu_b),
        .op (ctl.alu_op),
        .y  (alu_y),
        .eq (alu_eq)
    );

    scpu_nextpc #(.W(XLEN), .IDX_W(JIDX_W)) u_npc (
        .pc         (pc_q),
        .imm_ext    (imm_ext),
        .jidx       (fetch_word[JIDX_W-1:0]),
        .reg_target (rs_val),
        .sel        (ctl.npc),
        .br_ne      (ctl.br_ne),
        .eq         (alu_eq),
        .pc_plus4   (pc_plus4),
        .next_pc    (pc_next)
    );

    // Write-back selection
    always_comb begin
        unique case (ctl.dst)
            DST_RT:   rf_waddr = ins.rt;
            DST_LINK: rf_waddr = LINK_REG;
            default:  rf_waddr = ins.rd;
        endcase
        unique case (ctl.wb)
            WB_MEM:  rf_wdata = mem_rdata;
            WB_LINK: rf_wdata = pc_plus4;
            default: rf_wdata = alu_y;
        endcase
    end

    assign rf_we = ctl.reg_we & ~rst;

    always_ff @(posedge clk) begin
        if (rst) pc_q <= RESET_ADDR;
        else     pc_q <= pc_next;
    end

    assign fetch_addr = pc_q;
    assign mem_addr   = alu_y;
    assign mem_wdata  = rt_val;
    assign mem_we     = ctl.mem_we & ~rst;

    // R1: reset forces the start address
    p_reset_pc_r1: assert property (@(posedge clk)
        rst |=> (fetch_addr == RESET_ADDR));

    // R2: sequential instructions step the PC by one word
    p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
        (ctl.npc == NPC_SEQ) |=> (fetch_addr == $past(fetch_addr) + 32'd4));

    // R5: only the store opcode may raise the data strobe
    p_store_only_r5: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (fetch_word[31:26] == OPC_STORE));

    // R7: jump-and-link writes the return address to the link register
    p_link_write_r7: assert property (@(posedge clk) disable iff (rst)
        (fetch_word[31:26] == OPC_JLINK) |->
            (rf_we && rf_waddr == LINK_REG && rf_wdata == fetch_addr + 32'd4));

    // R10: undefined encodings change no register and no memory
    p_undef_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        ctl.illegal |-> (!rf_we && !mem_we));
endmodule

// File: tb/scpu_top_tb_top.sv
`timescale 1ns/1ps
module scpu_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fetch_addr, fetch_word, mem_addr, mem_wdata, mem_rdata;
    logic        mem_we;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    scpu_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .fetch_addr (fetch_addr),
        .fetch_word (fetch_word),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_we     (mem_we),
        .mem_rdata  (mem_rdata)
    );

    // Data memory model: 64 words, combinational read, write on rising edge
    logic [31:0] dmem [64];
    initial for (int i = 0; i < 64; i++) dmem[i] = 32'h0;
    assign mem_rdata = dmem[mem_addr[7:2]];
    always @(posedge clk) if (mem_we) dmem[mem_addr[7:2]] <= mem_wdata;

    // Encoders
    function automatic logic [31:0] er(input int rs, input int rt, input int rd, input int fn);
        er = {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
    endfunction
    function automatic logic [31:0] ei(input int op, input int rs, input int rt, input int imm);
        ei = {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
    endfunction
    function automatic logic [31:0] ej(input int op, input logic [31:0] target);
        ej = {op[5:0], target[27:2]};
    endfunction

    typedef struct packed {
        logic [31:0] instr;
        logic [31:0] pc;      // expected fetch_addr while this word executes
        logic        we;      // expected mem_we
        logic        chk;     // check mem_addr
        logic [31:0] addr;
        logic [31:0] wdata;   // checked when we = 1
        logic [7:0]  req;
    } step_t;

    localparam int NSTEP = 38;
    localparam step_t STEPS [NSTEP] = '{
        '{ei(8,0,1,5),         32'h00400000, 1'b0, 1'b0, 32'h00, 32'h0, 8'd4},  // R4 r1=5
        '{ei(8,0,2,-3),        32'h00400004, 1'b0, 1'b0, 32'h00, 32'h0, 8'd4},  // R4 r2=-3
        '{er(1,2,3,32),        32'h00400008, 1'b0, 1'b0, 32'h00, 32'h0, 8'd3},  // R3 add r3=2
        '{ei(43,0,3,0),        32'h0040000C, 1'b1, 1'b1, 32'h00, 32'h2, 8'd3},
        '{er(2,1,4,34),        32'h00400010, 1'b0, 1'b0, 32'h00, 32'h0, 8'd3},  // R3 sub r4=-8
        '{ei(43,0,4,4),        32'h00400014, 1'b1, 1'b1, 32'h04, 32'hFFFFFFF8, 8'd3},
        '{er(2,1,5,42),        32'h00400018, 1'b0, 1'b0, 32'h00, 32'h0, 8'd3},  // R3 slt r5=1
        '{er(1,2,6,42),        32'h0040001C, 1'b0, 1'b0, 32'h00, 32'h0, 8'd3},  // R3 slt r6=0
        '{ei(10,2,7,-2),       32'h00400020, 1'b0, 1'b0, 32'h00, 32'h0, 8'd4},  // R4 slti r7=1
        '{ei(10,1,8,5),        32'h00400024, 1'b0, 1'b0, 32'h00, 32'h0, 8'd4},  // R4 slti r8=0
        '{ei(43,0,5,8),        32'h00400028, 1'b1, 1'b1, 32'h08, 32'h1, 8'd3},
        '{ei(43,0,6,12),       32'h0040002C, 1'b1, 1'b1, 32'h0C, 32'h0, 8'd3},
        '{ei(43,0,7,16),       32'h00400030, 1'b1, 1'b1, 32'h10, 32'h1, 8'd4},
        '{ei(43,0,8,20),       32'h00400034, 1'b1, 1'b1, 32'h14, 32'h0, 8'd4},
        '{ei(8,1,0,7),         32'h00400038, 1'b0, 1'b0, 32'h00, 32'h0, 8'd9},  // R9 write r0
        '{ei(43,0,0,24),       32'h0040003C, 1'b1, 1'b1, 32'h18, 32'h0, 8'd9},
        '{ei(35,0,10,4),       32'h00400040, 1'b0, 1'b1, 32'h04, 32'h0, 8'd5},  // R5 load
        '{ei(43,1,10,27),      32'h00400044, 1'b1, 1'b1, 32'h20, 32'hFFFFFFF8, 8'd5},
        '{ei(43,1,1,-5),       32'h00400048, 1'b1, 1'b1, 32'h00, 32'h5, 8'd5},  // negative offset
        '{ei(4,1,2,4),         32'h0040004C, 1'b0, 1'b0, 32'h00, 32'h0, 8'd6},  // R6 beq not taken
        '{ei(4,3,3,2),         32'h00400050, 1'b0, 1'b0, 32'h00, 32'h0, 8'd6},  // beq taken
        '{ei(5,1,1,5),         32'h0040005C, 1'b0, 1'b0, 32'h00, 32'h0, 8'd6},  // bne not taken
        '{ei(5,1,2,-3),        32'h00400060, 1'b0, 1'b0, 32'h00, 32'h0, 8'd6},  // bne back
        '{ej(2,32'h00400100),  32'h00400058, 1'b0, 1'b0, 32'h00, 32'h0, 8'd7},  // R7 jump
        '{ej(3,32'h00400200),  32'h00400100, 1'b0, 1'b0, 32'h00, 32'h0, 8'd7},  // jal
        '{ei(43,0,31,36),      32'h00400200, 1'b1, 1'b1, 32'h24, 32'h00400104, 8'd7},
        '{ei(8,31,11,124),     32'h00400204, 1'b0, 1'b0, 32'h00, 32'h0, 8'd4},  // r11=0x400180
        '{er(11,0,0,8),        32'h00400208, 1'b0, 1'b0, 32'h00, 32'h0, 8'd8},  // R8 jr r11
        '{ei(63,0,1,1),        32'h00400180, 1'b0, 1'b0, 32'h00, 32'h0, 8'd10}, // R10 bad opcode
        '{er(0,0,1,63),        32'h00400184, 1'b0, 1'b0, 32'h00, 32'h0, 8'd10}, // bad funct
        '{ei(15,0,1,-1),       32'h00400188, 1'b0, 1'b0, 32'h00, 32'h0, 8'd10}, // unsupported op
        '{er(1,1,1,32) | 32'h000000C0,
                               32'h0040018C, 1'b0, 1'b0, 32'h00, 32'h0, 8'd10}, // shamt nonzero
        '{ei(43,0,1,40),       32'h00400190, 1'b1, 1'b1, 32'h28, 32'h5, 8'd10}, // r1 untouched
        '{er(31,0,0,8),        32'h00400194, 1'b0, 1'b0, 32'h00, 32'h0, 8'd8},  // jr r31
        '{ei(43,0,31,44),      32'h00400104, 1'b1, 1'b1, 32'h2C, 32'h00400104, 8'd7},
        '{ei(35,0,12,0),       32'h00400108, 1'b0, 1'b1, 32'h00, 32'h0, 8'd5},  // load mem[0]=5
        '{ei(43,0,12,48),      32'h0040010C, 1'b1, 1'b1, 32'h30, 32'h5, 8'd5},
        '{ei(43,0,2,52),       32'h00400110, 1'b1, 1'b1, 32'h34, 32'hFFFFFFFD, 8'd4}
    };

    task automatic check(input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL R%0d %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        fetch_word = ei(43,0,0,0);              // a store held during reset
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(1, "reset pc", fetch_addr, 32'h00400000);   // R1
        check(1, "we in reset", {31'b0, mem_we}, 32'h0);  // R1
        rst = 1'b0;

        for (int i = 0; i < NSTEP; i++) begin
            fetch_word = STEPS[i].instr;
            #1;
            check(int'(STEPS[i].req), $sformatf("step %0d pc", i), fetch_addr, STEPS[i].pc);
            check(int'(STEPS[i].req), $sformatf("step %0d we", i), {31'b0, mem_we},
                  {31'b0, STEPS[i].we});
            if (STEPS[i].chk)
                check(int'(STEPS[i].req), $sformatf("step %0d addr", i), mem_addr, STEPS[i].addr);
            if (STEPS[i].we)
                check(int'(STEPS[i].req), $sformatf("step %0d wdata", i), mem_wdata,
                      STEPS[i].wdata);
            @(negedge clk);
        end

        // R2: the last store advanced the PC by one word
        check(2, "pc after last step", fetch_addr, 32'h00400114);

        // R1: reset in mid-run blocks stores and reloads the start address
        rst = 1'b1;
        fetch_word = ei(43,0,1,0);
        #1;
        check(1, "we during mid-run reset", {31'b0, mem_we}, 32'h0);
        @(negedge clk);
        check(1, "pc after mid-run reset", fetch_addr, 32'h00400000);
        check(1, "memory word 0 kept", dmem[0], 32'h5);
        rst = 1'b0;

        // R9: r0 still reads zero after the attempted write
        fetch_word = ei(43,0,0,56);
        #1;
        check(9, "r0 reads zero", mem_wdata, 32'h0);
        @(negedge clk);
        check(2, "pc after store", fetch_addr, 32'h00400004);

        finish_run();
    end
endmodule